// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the two operand fields of an instruction, a 3-bit mode and a 3-bit register number, together with an operand size, into a description of where the operand lives. The result is a data register, an address register, a memory address, or the address of immediate data that sits in the instruction stream. Modes that need extension words fetch them one at a time through a request/response port and move the program counter past them. Modes that step an address register before or after use apply that step when the request is taken.

The block holds the program counter, eight data registers, seven address registers and two stack pointers. The highest address register number reaches one stack pointer or the other, depending on the privilege input. A decoder hands one operand request at a time to the block. The request and result sides are valid/ready channels. A request is taken only on a cycle where both `req_valid` and `req_ready` are high. Once `res_valid` is up, the result is held stable until a cycle with `res_ready` high, and only then is a new request taken. An extension-word request stays up with a stable address until `fetch_ready` is high. The word comes back later as a one-cycle pulse on `word_valid`, which cannot be back-pressured.

Top module: `ea_unit`

## Requirements
- R1: Modes 0 and 1 report a data register (kind code 0) or an address register (kind code 1) with `res_regnum` equal to the register field and `res_addr` of zero. No fetch is made, the PC does not change, and the result is valid in the cycle after the request is taken.
- R2: Mode 2 reports memory (kind code 2) at the address held in the named address register.
- R3: Mode 3 reports memory at the register's current value and adds the operand size in bytes to that register (size code 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes).
- R4: Mode 4 subtracts the operand size in bytes from the register, writes the result back, and reports that new value as the address.
- R5: Mode 5 fetches one word at the PC, advances the PC by 2, and reports the register plus the sign-extended word.
- R6: Mode 6 fetches one index word and reports base register + index + sign-extended 8-bit displacement. In that word, bits 7:0 hold the displacement and bit 8 picks an address (1) or data (0) index register. Bits 11:9 give the index register number. Bit 12 set uses the full 32-bit index; bit 12 clear uses the low 16 bits, sign-extended.
- R7: Mode 7 with register 2 (16-bit displacement) and register 3 (index word as in R6) form addresses relative to the address from which their extension word was fetched.
- R8: Mode 7 register 0 fetches one word, zero-extends it into the address, and advances the PC by 2. Register 1 fetches two words, the first being the upper half, and advances the PC by 4.
- R9: Mode 7 register 4 makes no fetch and reports kind code 3. For a byte the address is PC+1, otherwise it is the PC. The PC then advances by 4 for a long operand and by 2 for the others.
- R10: Address register 7 reads and writes the supervisor stack pointer while `priv_mode` is 1, and the user stack pointer while it is 0. This includes the mode 3 and mode 4 steps.
- R11: Mode 7 with register 5, 6 or 7 raises `res_illegal` with kind 0, register 0 and address 0. No register or PC changes and no fetch is made.
- R12: `req_ready` is high only while the block is idle. The result and a pending fetch request hold stable under back-pressure, and consecutive fetches use consecutive word addresses.
- R13: After reset all registers are zero, the PC equals `RESET_PC`, `req_ready` is high, and neither `res_valid` nor `fetch_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_mode | input | 1 | 1 selects the supervisor stack pointer for register 7 |
| pc_load | input | 1 | Load the PC with `pc_load_val` |
| pc_load_val | input | 32 | New PC value |
| pc_out | output | 32 | Current PC |
| req_valid | input | 1 | Operand request valid |
| req_ready | output | 1 | Block can take a request |
| req_mode | input | 3 | Mode field |
| req_reg | input | 3 | Register field |
| req_size | input | 2 | Size code: 0 byte, 1 word, 2 long |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_kind | output | 2 | 0 data reg, 1 address reg, 2 memory, 3 immediate |
| res_regnum | output | 3 | Register number for kinds 0 and 1 |
| res_addr | output | 32 | Operand address for kinds 2 and 3 |
| res_illegal | output | 1 | Unsupported mode/register pair |
| fetch_valid | output | 1 | Extension word request |
| fetch_ready | input | 1 | Request accepted |
| fetch_addr | output | 32 | Address of the requested word |
| word_valid | input | 1 | Returned word strobe |
| word_data | input | 16 | Returned word |
| wr_en | input | 1 | Register write strobe |
| wr_is_addr | input | 1 | 1 writes an address register |
| wr_num | input | 3 | Register number to write |
| wr_data | input | 32 | Write value |
| rd_is_addr | input | 1 | 1 reads an address register |
| rd_num | input | 3 | Register number to read |
| rd_data | output | 32 | Read value |

## Verification
The assertions assume several things about the inputs. `word_valid` pulses only while a fetched word is awaited. Size code 3 is never presented. `pc_load` and register writes happen only while the block is idle and no request is being taken. The stimulus keeps to all of this because it drives requests, PC loads, register writes and returned words from sequential tasks. Each task waits for the previous handshake to finish. The bench returns each word two cycles after its request is accepted and holds the result one cycle before taking it, so both stability properties are exercised.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned EXT_W   = 16;
  localparam int unsigned DISP8_W = 8;
  localparam int unsigned NUM_REG = 8;
  localparam int unsigned RNUM_W  = $clog2(NUM_REG);

  typedef enum logic [1:0] {
    KIND_DREG = 2'd0,
    KIND_AREG = 2'd1,
    KIND_MEM  = 2'd2,
    KIND_IMM  = 2'd3
  } opnd_kind_e;

  typedef enum logic [1:0] {
    SIZE_B = 2'd0,
    SIZE_W = 2'd1,
    SIZE_L = 2'd2
  } opnd_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_DONE
  } ea_state_e;

  function automatic logic [DATA_W-1:0] size_step(input logic [1:0] sz);
    case (sz)
      SIZE_L:  return DATA_W'(4);
      SIZE_W:  return DATA_W'(2);
      default: return DATA_W'(1);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] sext_ext(input logic [EXT_W-1:0] v);
    return {{(DATA_W-EXT_W){v[EXT_W-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] sext_d8(input logic [DISP8_W-1:0] v);
    return {{(DATA_W-DISP8_W){v[DISP8_W-1]}}, v};
  endfunction
endpackage

// File: rtl/ea_regfile.sv
module ea_regfile
  import ea_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned NREG = NUM_REG,
  parameter int unsigned NRD  = 3,
  parameter int unsigned IW   = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sup,
  input  logic                   wr_en,
  input  logic                   wr_is_addr,
  input  logic [IW-1:0]          wr_num,
  input  logic [DW-1:0]          wr_data,
  input  logic                   upd_en,
  input  logic [IW-1:0]          upd_num,
  input  logic [DW-1:0]          upd_data,
  input  logic [NRD-1:0]         rd_is_addr,
  input  logic [NRD-1:0][IW-1:0] rd_num,
  output logic [NRD-1:0][DW-1:0] rd_data
);
  localparam int unsigned SPN = NREG - 1;

  logic [DW-1:0] dreg [NREG];
  logic [DW-1:0] areg [SPN];
  logic [DW-1:0] usp_q;
  logic [DW-1:0] ssp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) dreg[i] <= '0;
      for (int i = 0; i < SPN; i++) areg[i] <= '0;
      usp_q <= '0;
      ssp_q <= '0;
    end else if (upd_en) begin
      if (upd_num == IW'(SPN)) begin
        if (sup) ssp_q <= upd_data;
        else     usp_q <= upd_data;
      end else begin
        areg[upd_num] <= upd_data;
      end
    end else if (wr_en) begin
      if (!wr_is_addr) begin
        dreg[wr_num] <= wr_data;
      end else if (wr_num == IW'(SPN)) begin
        if (sup) ssp_q <= wr_data;
        else     usp_q <= wr_data;
      end else begin
        areg[wr_num] <= wr_data;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (!rd_is_addr[p])              rd_data[p] = dreg[rd_num[p]];
      else if (rd_num[p] == IW'(SPN))  rd_data[p] = sup ? ssp_q : usp_q;
      else                             rd_data[p] = areg[rd_num[p]];
    end
  end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned EW = EXT_W
) (
  input  logic [2:0]    mode,
  input  logic [2:0]    regn,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] idx_raw,
  input  logic          idx_long,
  input  logic [EW-1:0] ext,
  input  logic [EW-1:0] hold,
  input  logic [DW-1:0] ext_pc,
  output logic [DW-1:0] addr
);
  logic [DW-1:0] idx_v;
  logic [DW-1:0] d16;
  logic [DW-1:0] d8;

  always_comb begin
    idx_v = idx_long ? idx_raw : DW'(sext_ext(idx_raw[EW-1:0]));
    d16   = DW'(sext_ext(ext));
    d8    = DW'(sext_d8(ext[DISP8_W-1:0]));
    addr  = '0;
    case (mode)
      3'd5: addr = base + d16;
      3'd6: addr = base + idx_v + d8;
      3'd7: begin
        case (regn)
          3'd0:    addr = DW'(ext);
          3'd1:    addr = DW'({hold, ext});
          3'd2:    addr = ext_pc + d16;
          3'd3:    addr = ext_pc + idx_v + d8;
          default: addr = '0;
        endcase
      end
      default: addr = '0;
    endcase
  end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        priv_mode,
  input  logic        pc_load,
  input  logic [31:0] pc_load_val,
  output logic [31:0] pc_out,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_mode,
  input  logic [2:0]  req_reg,
  input  logic [1:0]  req_size,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [1:0]  res_kind,
  output logic [2:0]  res_regnum,
  output logic [31:0] res_addr,
  output logic        res_illegal,
  output logic        fetch_valid,
  input  logic        fetch_ready,
  output logic [31:0] fetch_addr,
  input  logic        word_valid,
  input  logic [15:0] word_data,
  input  logic        wr_en,
  input  logic        wr_is_addr,
  input  logic [2:0]  wr_num,
  input  logic [31:0] wr_data,
  input  logic        rd_is_addr,
  input  logic [2:0]  rd_num,
  output logic [31:0] rd_data
);
  localparam int unsigned NRD      = 3;
  localparam int unsigned IDX_SEL  = 8;
  localparam int unsigned IDX_NUM  = 9;
  localparam int unsigned IDX_LONG = 12;

  ea_state_e state_q;
  logic [2:0]        mode_q, reg_q;
  logic              second_q;
  logic [EXT_W-1:0]  hold_q;
  logic [DATA_W-1:0] ext_pc_q, pc_q;
  logic [1:0]        kind_q;
  logic [2:0]        regnum_q;
  logic [DATA_W-1:0] addr_q;
  logic              illegal_q;

  logic [NRD-1:0]              rf_is_addr;
  logic [NRD-1:0][RNUM_W-1:0]  rf_num;
  logic [NRD-1:0][DATA_W-1:0]  rf_data;
  logic              upd_en;
  logic [DATA_W-1:0] upd_val, step, base, calc_addr;
  logic              idle, take, is7, want_fetch, want_two, is_imm, is_bad;

  always_comb begin
    idle       = (state_q == ST_IDLE);
    take       = idle && req_valid;
    is7        = (req_mode == 3'd7);
    want_fetch = (req_mode == 3'd5) || (req_mode == 3'd6) || (is7 && req_reg <= 3'd3);
    want_two   = is7 && (req_reg == 3'd1);
    is_imm     = is7 && (req_reg == 3'd4);
    is_bad     = is7 && (req_reg >= 3'd5);
    step       = size_step(req_size);

    rf_is_addr[0] = 1'b1;
    rf_num[0]     = idle ? req_reg : reg_q;
    rf_is_addr[1] = word_data[IDX_SEL];
    rf_num[1]     = word_data[IDX_NUM +: RNUM_W];
    rf_is_addr[2] = rd_is_addr;
    rf_num[2]     = rd_num;
    base          = rf_data[0];
    rd_data       = rf_data[2];

    upd_en  = take && ((req_mode == 3'd3) || (req_mode == 3'd4));
    upd_val = (req_mode == 3'd3) ? base + step : base - step;
  end

  ea_regfile #(.DW(DATA_W), .NREG(NUM_REG), .NRD(NRD), .IW(RNUM_W)) u_rf (
    .clk        (clk),
    .rst_n      (rst_n),
    .sup        (priv_mode),
    .wr_en      (wr_en),
    .wr_is_addr (wr_is_addr),
    .wr_num     (wr_num),
    .wr_data    (wr_data),
    .upd_en     (upd_en),
    .upd_num    (req_reg),
    .upd_data   (upd_val),
    .rd_is_addr (rf_is_addr),
    .rd_num     (rf_num),
    .rd_data    (rf_data)
  );

  ea_calc #(.DW(DATA_W), .EW(EXT_W)) u_calc (
    .mode     (mode_q),
    .regn     (reg_q),
    .base     (base),
    .idx_raw  (rf_data[1]),
    .idx_long (word_data[IDX_LONG]),
    .ext      (word_data),
    .hold     (hold_q),
    .ext_pc   (ext_pc_q),
    .addr     (calc_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mode_q    <= '0;
      reg_q     <= '0;
      second_q  <= 1'b0;
      hold_q    <= '0;
      ext_pc_q  <= '0;
      pc_q      <= RESET_PC;
      kind_q    <= KIND_DREG;
      regnum_q  <= '0;
      addr_q    <= '0;
      illegal_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            mode_q    <= req_mode;
            reg_q     <= req_reg;
            kind_q    <= KIND_DREG;
            regnum_q  <= '0;
            addr_q    <= '0;
            illegal_q <= 1'b0;
            second_q  <= want_two;
            if (is_bad) begin
              illegal_q <= 1'b1;
              state_q   <= ST_DONE;
            end else if (want_fetch) begin
              state_q <= ST_FETCH;
            end else begin
              state_q <= ST_DONE;
              case (req_mode)
                3'd0: regnum_q <= req_reg;
                3'd1: begin
                  kind_q   <= KIND_AREG;
                  regnum_q <= req_reg;
                end
                3'd2, 3'd3: begin
                  kind_q <= KIND_MEM;
                  addr_q <= base;
                end
                3'd4: begin
                  kind_q <= KIND_MEM;
                  addr_q <= base - step;
                end
                default: begin
                  if (is_imm) begin
                    kind_q <= KIND_IMM;
                    addr_q <= pc_q + ((req_size == SIZE_B) ? DATA_W'(1) : DATA_W'(0));
                    pc_q   <= pc_q + ((req_size == SIZE_L) ? DATA_W'(4) : DATA_W'(2));
                  end
                end
              endcase
            end
          end
        end
        ST_FETCH: begin
          if (fetch_ready) begin
            ext_pc_q <= pc_q;
            state_q  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (word_valid) begin
            pc_q <= pc_q + DATA_W'(2);
            if (second_q) begin
              hold_q   <= word_data;
              second_q <= 1'b0;
              state_q  <= ST_FETCH;
            end else begin
              kind_q  <= KIND_MEM;
              addr_q  <= calc_addr;
              state_q <= ST_DONE;
            end
          end
        end
        default: begin
          if (res_ready) state_q <= ST_IDLE;
        end
      endcase
      if (pc_load) pc_q <= pc_load_val;
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign res_valid   = (state_q == ST_DONE);
  assign fetch_valid = (state_q == ST_FETCH);
  assign fetch_addr  = pc_q;
  assign pc_out      = pc_q;
  assign res_kind    = kind_q;
  assign res_regnum  = regnum_q;
  assign res_addr    = addr_q;
  assign res_illegal = illegal_q;
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pc_load,
  input logic [31:0] pc_out,
  input logic        req_valid,
  input logic        req_ready,
  input logic [2:0]  req_mode,
  input logic [2:0]  req_reg,
  input logic [1:0]  req_size,
  input logic        res_valid,
  input logic        res_ready,
  input logic [1:0]  res_kind,
  input logic [2:0]  res_regnum,
  input logic [31:0] res_addr,
  input logic        res_illegal,
  input logic        fetch_valid,
  input logic        fetch_ready,
  input logic [31:0] fetch_addr,
  input logic        word_valid
);
  logic taken;
  assign taken = req_valid && req_ready && !pc_load;

  // R12
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_addr) && $stable(res_kind)
                                && $stable(res_regnum) && $stable(res_illegal));

  // R12
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_addr));

  // R11
  illegal_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken && req_mode == 3'd7 && req_reg >= 3'd5
    |=> res_valid && res_illegal && $stable(pc_out) && !fetch_valid);

  // R9
  imm_pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken && req_mode == 3'd7 && req_reg == 3'd4
    |=> res_valid && res_kind == 2'd3
        && pc_out == $past(pc_out) + (($past(req_size) == 2'd2) ? 32'd4 : 32'd2));

  // R1
  direct_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken && req_mode <= 3'd1
    |=> res_valid && !res_illegal && res_regnum == $past(req_reg)
        && res_kind == {1'b0, $past(req_mode[0])} && $stable(pc_out));

  // R5
  word_pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !pc_load && !req_ready && !fetch_valid && !res_valid
    |=> pc_out == $past(pc_out) + 32'd2);
endmodule

bind ea_unit ea_unit_chk u_ea_unit_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pc_load     (pc_load),
  .pc_out      (pc_out),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_mode    (req_mode),
  .req_reg     (req_reg),
  .req_size    (req_size),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_kind    (res_kind),
  .res_regnum  (res_regnum),
  .res_addr    (res_addr),
  .res_illegal (res_illegal),
  .fetch_valid (fetch_valid),
  .fetch_ready (fetch_ready),
  .fetch_addr  (fetch_addr),
  .word_valid  (word_valid)
);

// File: tb/test_ea_unit.sv
module test_ea_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, priv_mode, pc_load;
  logic [31:0] pc_load_val, pc_out;
  logic        req_valid, req_ready;
  logic [2:0]  req_mode, req_reg;
  logic [1:0]  req_size;
  logic        res_valid, res_ready;
  logic [1:0]  res_kind;
  logic [2:0]  res_regnum;
  logic [31:0] res_addr;
  logic        res_illegal;
  logic        fetch_valid, fetch_ready;
  logic [31:0] fetch_addr;
  logic        word_valid;
  logic [15:0] word_data;
  logic        wr_en, wr_is_addr;
  logic [2:0]  wr_num;
  logic [31:0] wr_data;
  logic        rd_is_addr;
  logic [2:0]  rd_num;
  logic [31:0] rd_data;

  ea_unit i_ea_unit (
    .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .pc_load(pc_load),
    .pc_load_val(pc_load_val), .pc_out(pc_out), .req_valid(req_valid),
    .req_ready(req_ready), .req_mode(req_mode), .req_reg(req_reg),
    .req_size(req_size), .res_valid(res_valid), .res_ready(res_ready),
    .res_kind(res_kind), .res_regnum(res_regnum), .res_addr(res_addr),
    .res_illegal(res_illegal), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .word_valid(word_valid), .word_data(word_data), .wr_en(wr_en),
    .wr_is_addr(wr_is_addr), .wr_num(wr_num), .wr_data(wr_data),
    .rd_is_addr(rd_is_addr), .rd_num(rd_num), .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  typedef struct packed {
    logic [2:0]  mode;
    logic [2:0]  rn;
    logic [1:0]  sz;
    logic [15:0] w0;
    logic [15:0] w1;
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [2:0]  dpc;
    logic [1:0]  nf;
    logic        ill;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VT [NV] = '{
    '{3'd0, 3'd5, 2'd1, 16'h0000, 16'h0000, 2'd0, 32'h0000_0000, 3'd0, 2'd0, 1'b0},
    '{3'd1, 3'd7, 2'd2, 16'h0000, 16'h0000, 2'd1, 32'h0000_0000, 3'd0, 2'd0, 1'b0},
    '{3'd2, 3'd2, 2'd1, 16'h0000, 16'h0000, 2'd2, 32'h0010_2000, 3'd0, 2'd0, 1'b0},
    '{3'd5, 3'd1, 2'd1, 16'hFFFE, 16'h0000, 2'd2, 32'h0010_0FFE, 3'd2, 2'd1, 1'b0},
    '{3'd5, 3'd0, 2'd0, 16'h7FFF, 16'h0000, 2'd2, 32'h0010_7FFF, 3'd2, 2'd1, 1'b0},
    '{3'd6, 3'd4, 2'd1, 16'h0620, 16'h0000, 2'd2, 32'h0010_4010, 3'd2, 2'd1, 1'b0},
    '{3'd6, 3'd0, 2'd2, 16'h1DFC, 16'h0000, 2'd2, 32'h0020_5FFC, 3'd2, 2'd1, 1'b0},
    '{3'd6, 3'd1, 2'd1, 16'h0A00, 16'h0000, 2'd2, 32'h000F_9000, 3'd2, 2'd1, 1'b0},
    '{3'd6, 3'd1, 2'd0, 16'h1A01, 16'h0000, 2'd2, 32'h0011_9001, 3'd2, 2'd1, 1'b0},
    '{3'd7, 3'd2, 2'd1, 16'h0010, 16'h0000, 2'd2, 32'h0000_4010, 3'd2, 2'd1, 1'b0},
    '{3'd7, 3'd2, 2'd1, 16'hFF00, 16'h0000, 2'd2, 32'h0000_3F00, 3'd2, 2'd1, 1'b0},
    '{3'd7, 3'd3, 2'd2, 16'h1F80, 16'h0000, 2'd2, 32'h0020_3F80, 3'd2, 2'd1, 1'b0},
    '{3'd7, 3'd0, 2'd1, 16'h8000, 16'h0000, 2'd2, 32'h0000_8000, 3'd2, 2'd1, 1'b0},
    '{3'd7, 3'd1, 2'd2, 16'h00AB, 16'hCDEF, 2'd2, 32'h00AB_CDEF, 3'd4, 2'd2, 1'b0},
    '{3'd7, 3'd4, 2'd0, 16'h0000, 16'h0000, 2'd3, 32'h0000_4001, 3'd2, 2'd0, 1'b0},
    '{3'd7, 3'd4, 2'd1, 16'h0000, 16'h0000, 2'd3, 32'h0000_4000, 3'd2, 2'd0, 1'b0},
    '{3'd7, 3'd4, 2'd2, 16'h0000, 16'h0000, 2'd3, 32'h0000_4000, 3'd4, 2'd0, 1'b0},
    '{3'd7, 3'd5, 2'd1, 16'h0000, 16'h0000, 2'd0, 32'h0000_0000, 3'd0, 2'd0, 1'b1},
    '{3'd7, 3'd6, 2'd0, 16'h0000, 16'h0000, 2'd0, 32'h0000_0000, 3'd0, 2'd0, 1'b1},
    '{3'd7, 3'd7, 2'd2, 16'h0000, 16'h0000, 2'd0, 32'h0000_0000, 3'd0, 2'd0, 1'b1}
  };

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string req_tag(input logic [2:0] m, input logic [2:0] r);
    case (m)
      3'd0, 3'd1: return "R1";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R6";
      default: begin
        if (r == 3'd2 || r == 3'd3) return "R7";
        if (r <= 3'd1) return "R8";
        if (r == 3'd4) return "R9";
        return "R11";
      end
    endcase
  endfunction

  task automatic put_reg(input logic isa, input logic [2:0] num, input logic [31:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_is_addr = isa; wr_num = num; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic get_reg(input logic isa, input logic [2:0] num, output logic [31:0] val);
    rd_is_addr = isa; rd_num = num;
    #1 val = rd_data;
  endtask

  task automatic load_pc(input logic [31:0] v);
    @(negedge clk);
    pc_load = 1'b1; pc_load_val = v;
    @(negedge clk);
    pc_load = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] m, input logic [2:0] r, input logic [1:0] sz,
                        input logic [15:0] w0, input logic [15:0] w1,
                        output logic [1:0] kind, output logic [2:0] rnum,
                        output logic [31:0] addr, output logic ill,
                        output int nf, output bit stable_ok, output bit fetch_ok);
    logic [31:0] pc0;
    int guard;
    @(negedge clk);
    pc0 = pc_out;
    req_valid = 1'b1; req_mode = m; req_reg = r; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    nf = 0; guard = 0; fetch_ok = 1'b1;
    while (!res_valid && guard < 50) begin
      if (fetch_valid) begin
        if (fetch_addr !== pc0 + 32'(2 * nf)) fetch_ok = 1'b0;
        fetch_ready = 1'b1;
        @(negedge clk);
        fetch_ready = 1'b0;
        @(negedge clk);
        word_valid = 1'b1;
        word_data  = (nf == 0) ? w0 : w1;
        @(negedge clk);
        word_valid = 1'b0;
        nf++;
      end else begin
        @(negedge clk);
      end
      guard++;
    end
    kind = res_kind; rnum = res_regnum; addr = res_addr; ill = res_illegal;
    @(negedge clk);
    stable_ok = res_valid && (res_kind === kind) && (res_regnum === rnum)
                && (res_addr === addr) && (res_illegal === ill);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R12 watchdog expired actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [1:0]  kind;
    logic [2:0]  rnum;
    logic [31:0] addr, v;
    logic        ill;
    int          nf;
    bit          st_ok, f_ok;
    string       tg;

    rst_n = 1'b0; priv_mode = 1'b0; pc_load = 1'b0; pc_load_val = '0;
    req_valid = 1'b0; req_mode = '0; req_reg = '0; req_size = '0;
    res_ready = 1'b0; fetch_ready = 1'b0; word_valid = 1'b0; word_data = '0;
    wr_en = 1'b0; wr_is_addr = 1'b0; wr_num = '0; wr_data = '0;
    rd_is_addr = 1'b0; rd_num = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk("R13", "req_ready", 32'(req_ready), 32'd1);
    chk("R13", "res_valid", 32'(res_valid), 32'd0);
    chk("R13", "fetch_valid", 32'(fetch_valid), 32'd0);
    chk("R13", "pc", pc_out, 32'h0);
    get_reg(1'b0, 3'd0, v); chk("R13", "D0", v, 32'h0);
    get_reg(1'b1, 3'd7, v); chk("R13", "A7", v, 32'h0);

    for (int n = 0; n < 8; n++) put_reg(1'b0, 3'(n), 32'h100 * 32'(n + 1));
    put_reg(1'b0, 3'd3, 32'hFFFF_FFF0);
    put_reg(1'b0, 3'd5, 32'h0001_8000);
    for (int n = 0; n < 7; n++) put_reg(1'b1, 3'(n), 32'h0010_0000 + 32'h1000 * 32'(n));
    priv_mode = 1'b1;
    put_reg(1'b1, 3'd7, 32'h0030_0000);
    priv_mode = 1'b0;
    put_reg(1'b1, 3'd7, 32'h0020_0000);

    for (int i = 0; i < NV; i++) begin
      load_pc(32'h0000_4000);
      run_op(VT[i].mode, VT[i].rn, VT[i].sz, VT[i].w0, VT[i].w1,
             kind, rnum, addr, ill, nf, st_ok, f_ok);
      tg = req_tag(VT[i].mode, VT[i].rn);
      chk(tg, "kind", 32'(kind), 32'(VT[i].kind));
      chk(tg, "regnum", 32'(rnum),
          (VT[i].kind <= 2'd1 && !VT[i].ill) ? 32'(VT[i].rn) : 32'd0);
      chk(tg, "addr", addr, VT[i].addr);
      chk(tg, "illegal", 32'(ill), 32'(VT[i].ill));
      chk(tg, "pc advance", pc_out - 32'h4000, 32'(VT[i].dpc));
      chk(tg, "fetch count", 32'(nf), 32'(VT[i].nf));
      chk("R12", "result held", 32'(st_ok), 32'd1);
      chk("R12", "fetch addresses", 32'(f_ok), 32'd1);
    end

    // R3 post-increment by size
    run_op(3'd3, 3'd2, 2'd0, 16'h0, 16'h0, kind, rnum, addr, ill, nf, st_ok, f_ok);
    chk("R3", "addr byte", addr, 32'h0010_2000);
    get_reg(1'b1, 3'd2, v); chk("R3", "A2 after byte", v, 32'h0010_2001);
    run_op(3'd3, 3'd3, 2'd1, 16'h0, 16'h0, kind, rnum, addr, ill, nf, st_ok, f_ok);
    chk("R3", "addr word", addr, 32'h0010_3000);
    get_reg(1'b1, 3'd3, v); chk("R3", "A3 after word", v, 32'h0010_3002);
    run_op(3'd3, 3'd5, 2'd2, 16'h0, 16'h0, kind, rnum, addr, ill, nf, st_ok, f_ok);
    chk("R3", "kind", 32'(kind), 32'd2);
    get_reg(1'b1, 3'd5, v); chk("R3", "A5 after long", v, 32'h0010_5004);

    // R4 pre-decrement by size
    run_op(3'd4, 3'd4, 2'd2, 16'h0, 16'h0, kind, rnum, addr, ill, nf, st_ok, f_ok);
    chk("R4", "addr long", addr, 32'h0010_3FFC);
    get_reg(1'b1, 3'd4, v); chk("R4", "A4 after long", v, 32'h0010_3FFC);
    run_op(3'd4, 3'd6, 2'd0, 16'h0, 16'h0, kind, rnum, addr, ill, nf, st_ok, f_ok);
    chk("R4", "addr byte", addr, 32'h0010_5FFF);
    get_reg(1'b1, 3'd6, v); chk("R4", "A6 after byte", v, 32'h0010_5FFF);

    // R10 stack pointer banking
    priv_mode = 1'b1;
    get_reg(1'b1, 3'd7, v); chk("R10", "A7 supervisor", v, 32'h0030_0000);
    run_op(3'd2, 3'd7, 2'd1, 16'h0, 16'h0, kind, rnum, addr, ill, nf, st_ok, f_ok);
    chk("R10", "indirect supervisor", addr, 32'h0030_0000);
    run_op(3'd3, 3'd7, 2'd1, 16'h0, 16'h0, kind, rnum, addr, ill, nf, st_ok, f_ok);
    get_reg(1'b1, 3'd7, v); chk("R10", "supervisor stepped", v, 32'h0030_0002);
    priv_mode = 1'b0;
    get_reg(1'b1, 3'd7, v); chk("R10", "user untouched", v, 32'h0020_0000);
    run_op(3'd4, 3'd7, 2'd2, 16'h0, 16'h0, kind, rnum, addr, ill, nf, st_ok, f_ok);
    chk("R10", "user predec addr", addr, 32'h001F_FFFC);
    priv_mode = 1'b1;
    get_reg(1'b1, 3'd7, v); chk("R10", "supervisor kept", v, 32'h0030_0002);
    priv_mode = 1'b0;

    // R11 illegal pair leaves registers and PC alone
    load_pc(32'h0000_6000);
    run_op(3'd7, 3'd5, 2'd2, 16'h0, 16'h0, kind, rnum, addr, ill, nf, st_ok, f_ok);
    chk("R11", "illegal flag", 32'(ill), 32'd1);
    chk("R11", "pc", pc_out, 32'h0000_6000);
    get_reg(1'b1, 3'd5, v); chk("R11", "A5 kept", v, 32'h0010_5004);

    done = 1'b1;
    report();
    $finish;
  end
endmodule